// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Controller

This block follows the low-power state of a synchronous DRAM device from its clock-enable pin. On every rising clock edge it compares the clock-enable sample taken on that edge with the sample taken one edge earlier. It combines that comparison with the chip-select, row-strobe, column-strobe and write-enable command pins and with a flag from the bank logic that says whether every bank is idle. From these it decides between four states: running, power down, clock suspend and self refresh.

The block drives three things. The first is an internal clock enable for the rest of the device core. The second is a command strobe that tells the bank logic whether the command on the pins is taken on this edge. The third is the pair of data-mask controls: a write-data mask with no added delay, and a read-output high-impedance control that lags the mask pin by two internal clocks. Wake-up analogue effects and refresh row generation are handled elsewhere.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the status is running (code 00), the internal clock enable is 1 and the read high-impedance output is 0.
- R2: In the running state, with all banks idle, clock enable sampled high on the previous edge and low on this edge, and a NOP (chip select low, other three strobes high) or a deselect (chip select high) on the pins, the status becomes power down (code 01) after that edge.
- R3: Under the same conditions as R2 but with the auto-refresh encoding on the pins (chip select, row and column strobes low, write enable high), the status becomes self refresh (code 11) after that edge, and that command is not passed to the bank logic.
- R4: In the running state with at least one bank not idle, a high-to-low clock-enable transition makes the status clock suspend (code 10) after that edge, whatever the command. The command on that edge is still passed on, and the internal clock enable is low from the following cycle (one-clock entry latency).
- R5: Clock suspend lasts for as long as clock enable is sampled low. The first edge that samples it high returns the status to running, whatever the command.
- R6: Power down is left only on an edge that samples clock enable high with a NOP or deselect on the pins. Any other command on such an edge leaves the block in power down.
- R7: Self refresh is left under the same condition as R6. During the one cycle after the exit edge, no command is passed to the bank logic.
- R8: In power down and self refresh, the command strobe stays low and the read high-impedance output keeps its value, whatever the command, bank-idle and mask inputs do.
- R9: The write-data mask output equals the mask pin in the same cycle.
- R10: The read high-impedance output shows the mask value sampled two internal clocks earlier. An edge counts as an internal clock only when the status before it is running.
- R11: The internal clock enable is 1 exactly when the status is running.
- R12: In the running state, outside the blocked cycle of R7 and outside an R2/R3 entry edge, the command strobe equals the inverse of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| banks_idle | input | 1 | 1 when every bank is precharged and idle |
| dqm | input | 1 | Data-mask pin |
| core_clk_en | output | 1 | Internal clock enable for the device core |
| cmd_strobe | output | 1 | The pin command is taken by the bank logic on this edge |
| wr_mask | output | 1 | Blocks write data in this cycle |
| rd_hiz | output | 1 | Forces the read output to high impedance |
| pwr_status | output | 2 | 00 running, 01 power down, 10 clock suspend, 11 self refresh |

## Verification
The hardest case to reach is the cycle right after a self-refresh exit. Getting there takes a full chain of events: an idle entry edge carrying the refresh encoding, a stretch with clock enable low while the other pins toggle, and an exit edge carrying a NOP. The bench runs this chain and then puts a read command on the pins in the very next cycle, so the blocked strobe can be seen. A second hard case is the frozen read-mask pipeline. The bench toggles the mask pin during suspend and during power down and then checks that the high-impedance output resumes with the values that were sampled before the freeze.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'b00,
      PS_PDN  = 2'b01,
      PS_SUSP = 2'b10,
      PS_SREF = 2'b11
   } pwr_state_t;

   // NOP or deselect on the command pins
   function automatic logic cmd_is_quiet(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
      return cs_n | (ras_n & cas_n & we_n);
   endfunction

   // Auto-refresh encoding; the same code requests self refresh when cke falls
   function automatic logic cmd_is_refresh(input logic cs_n, input logic ras_n,
                                           input logic cas_n, input logic we_n);
      return ~cs_n & ~ras_n & ~cas_n & we_n;
   endfunction

endpackage

// File: rtl/cke_sampler.sv
module cke_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   output logic cke_prev,
   output logic cke_fall
);
   always_ff @(posedge clk) begin
      if (!rst_n) cke_prev <= 1'b1;
      else        cke_prev <= cke;
   end

   assign cke_fall = cke_prev & ~cke;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
   import sdram_cke_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       cke_fall,
   input  logic       quiet_cmd,
   input  logic       refresh_cmd,
   input  logic       banks_idle,
   output pwr_state_t state,
   output logic       exit_hold,
   output logic       idle_entry
);
   pwr_state_t state_nx;
   logic       hold_nx;

   assign idle_entry = (state == PS_RUN) & cke_fall & banks_idle;

   always_comb begin
      state_nx = state;
      hold_nx  = 1'b0;
      unique case (state)
         PS_RUN: begin
            if (cke_fall) begin
               if (!banks_idle)      state_nx = PS_SUSP;
               else if (refresh_cmd) state_nx = PS_SREF;
               else                  state_nx = PS_PDN;
            end
         end
         PS_PDN: begin
            if (cke && quiet_cmd) state_nx = PS_RUN;
         end
         PS_SUSP: begin
            if (cke) state_nx = PS_RUN;
         end
         PS_SREF: begin
            if (cke && quiet_cmd) begin
               state_nx = PS_RUN;
               hold_nx  = 1'b1;
            end
         end
         default: state_nx = PS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= PS_RUN;
         exit_hold <= 1'b0;
      end else begin
         state     <= state_nx;
         exit_hold <= hold_nx;
      end
   end
endmodule

// File: rtl/mask_delay.sv
module mask_delay #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   input  logic din,
   output logic dout
);
   generate
      if (LAT == 0) begin : g_direct
         assign dout = din;
      end else begin : g_pipe
         logic [LAT-1:0] stage;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage <= '0;
            end else if (advance) begin
               if (LAT == 1) stage[0] <= din;
               else          stage    <= {stage[LAT-2:0], din};
            end
         end
         assign dout = stage[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
   import sdram_cke_pkg::*;
#(
   parameter int RD_MASK_LAT = 2,
   parameter int WR_MASK_LAT = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cke,
   input  logic       cs_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       banks_idle,
   input  logic       dqm,
   output logic       core_clk_en,
   output logic       cmd_strobe,
   output logic       wr_mask,
   output logic       rd_hiz,
   output logic [1:0] pwr_status
);
   localparam int MAX_LAT = 8;

   generate
      if (RD_MASK_LAT < 0 || RD_MASK_LAT > MAX_LAT) begin : g_bad_rd
         $error("RD_MASK_LAT out of range");
      end
      if (WR_MASK_LAT < 0 || WR_MASK_LAT > MAX_LAT) begin : g_bad_wr
         $error("WR_MASK_LAT out of range");
      end
   endgenerate

   logic       cke_prev, cke_fall;
   logic       quiet_cmd, refresh_cmd;
   pwr_state_t state;
   logic       exit_hold, idle_entry;

   assign quiet_cmd   = cmd_is_quiet(cs_n, ras_n, cas_n, we_n);
   assign refresh_cmd = cmd_is_refresh(cs_n, ras_n, cas_n, we_n);

   cke_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .cke_prev (cke_prev),
      .cke_fall (cke_fall)
   );

   pwr_state_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cke         (cke),
      .cke_fall    (cke_fall),
      .quiet_cmd   (quiet_cmd),
      .refresh_cmd (refresh_cmd),
      .banks_idle  (banks_idle),
      .state       (state),
      .exit_hold   (exit_hold),
      .idle_entry  (idle_entry)
   );

   assign core_clk_en = (state == PS_RUN);
   assign cmd_strobe  = core_clk_en & ~exit_hold & ~cs_n & ~idle_entry;
   assign pwr_status  = state;

   mask_delay #(.LAT(WR_MASK_LAT)) u_wmask (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (core_clk_en),
      .din     (dqm),
      .dout    (wr_mask)
   );

   mask_delay #(.LAT(RD_MASK_LAT)) u_rmask (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (core_clk_en),
      .din     (dqm),
      .dout    (rd_hiz)
   );
endmodule

// File: rtl/sdram_cke_ctrl_chk.sv
module sdram_cke_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic       cke_prev,
   input logic       cs_n,
   input logic       ras_n,
   input logic       cas_n,
   input logic       we_n,
   input logic       banks_idle,
   input logic       core_clk_en,
   input logic       cmd_strobe,
   input logic       rd_hiz,
   input logic [1:0] pwr_status
);
   logic quiet, refr;
   assign quiet = cs_n | (ras_n & cas_n & we_n);
   assign refr  = ~cs_n & ~ras_n & ~cas_n & we_n;

   assert_pd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b00 && cke_prev && !cke && banks_idle && quiet) |=> pwr_status == 2'b01);

   assert_sr_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b00 && cke_prev && !cke && banks_idle && refr) |=> pwr_status == 2'b11);

   assert_susp_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b00 && cke_prev && !cke && !banks_idle) |=> (pwr_status == 2'b10 && !core_clk_en));

   assert_susp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b10 && !cke) |=> pwr_status == 2'b10);

   assert_pd_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b01 && !(cke && quiet)) |=> pwr_status == 2'b01);

   assert_srx_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b11 && cke && quiet) |=> !cmd_strobe);

   assert_quiet_lowpwr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status == 2'b01 || pwr_status == 2'b11) |-> !cmd_strobe);

   assert_rd_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_status != 2'b00) |=> $stable(rd_hiz));
endmodule

bind sdram_cke_ctrl sdram_cke_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cke_prev    (cke_prev),
   .cs_n        (cs_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .banks_idle  (banks_idle),
   .core_clk_en (core_clk_en),
   .cmd_strobe  (cmd_strobe),
   .rd_hiz      (rd_hiz),
   .pwr_status  (pwr_status)
);

// File: tb/sim_sdram_cke_ctrl.sv
module sim_sdram_cke_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic banks_idle = 1'b1, dqm = 1'b0;
   logic core_clk_en, cmd_strobe, wr_mask, rd_hiz;
   logic [1:0] pwr_status;

   int checks = 0;
   int errors = 0;

   // reference model
   int m_st = 0;
   bit m_ckep = 1'b1;
   bit m_hold = 1'b0;
   bit m_q[$];

   always #5 clk = ~clk;

   sdram_cke_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle), .dqm(dqm),
      .core_clk_en(core_clk_en), .cmd_strobe(cmd_strobe), .wr_mask(wr_mask),
      .rd_hiz(rd_hiz), .pwr_status(pwr_status)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // cmd = {cs_n, ras_n, cas_n, we_n}
   task automatic step(input bit k, input bit [3:0] cmd, input bit idle,
                       input bit m, input string tag);
      bit quiet, refr;
      int nx;
      bit exp_strobe;
      @(negedge clk);
      cke = k; {cs_n, ras_n, cas_n, we_n} = cmd; banks_idle = idle; dqm = m;
      #1;
      quiet = cmd[3] | (cmd[2] & cmd[1] & cmd[0]);
      refr  = (cmd == 4'b0001);
      exp_strobe = (m_st == 0) && !m_hold && !cmd[3] && !(m_ckep && !k && idle);
      check({tag, " status"}, pwr_status, m_st);
      check("R11 core_clk_en", core_clk_en, (m_st == 0));
      check((m_st == 1 || m_st == 3) ? "R8 cmd_strobe" :
            (m_hold ? "R7 cmd_strobe" : "R12 cmd_strobe"), cmd_strobe, exp_strobe);
      check("R9 wr_mask", wr_mask, m);
      check("R10 rd_hiz", rd_hiz, m_q[0]);
      @(posedge clk);
      nx = m_st;
      case (m_st)
         0: if (m_ckep && !k) nx = !idle ? 2 : (refr ? 3 : 1);
         1: if (k && quiet) nx = 0;
         2: if (k) nx = 0;
         default: if (k && quiet) nx = 0;
      endcase
      if (m_st == 0) begin
         m_q.push_back(m);
         void'(m_q.pop_front());
      end
      m_hold = (m_st == 3) && (nx == 0);
      m_st   = nx;
      m_ckep = k;
   endtask

   localparam bit [3:0] NOP = 4'b0111, DES = 4'b1111, REF = 4'b0001,
                        RD  = 4'b0101, ACT = 4'b0011, WR = 4'b0100;

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_q.push_back(1'b0);
      m_q.push_back(1'b0);
      repeat (3) @(posedge clk);
      #1;
      check("R1 status in reset", pwr_status, 0);
      check("R1 clk_en in reset", core_clk_en, 1);
      check("R1 rd_hiz in reset", rd_hiz, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // running, mask pattern through the read pipe
      step(1, NOP, 1, 1, "R1");
      step(1, RD,  0, 0, "R10");
      step(1, WR,  0, 1, "R10");
      step(1, NOP, 1, 1, "R10");
      step(1, DES, 1, 0, "R10");
      // power down via NOP, noise inside, rejected exit, then exit
      step(0, NOP, 1, 1, "R2");
      step(0, ACT, 0, 0, "R8");
      step(0, RD,  1, 1, "R8");
      step(1, ACT, 1, 0, "R6");
      step(1, RD,  0, 1, "R6");
      step(1, NOP, 1, 0, "R6");
      step(1, NOP, 1, 0, "R6");
      // power down via deselect, exit with deselect
      step(0, DES, 1, 1, "R2");
      step(0, REF, 1, 0, "R8");
      step(1, DES, 1, 1, "R6");
      step(1, NOP, 1, 0, "R6");
      // self refresh, noise, rejected exit, exit, blocked read
      step(0, REF, 1, 1, "R3");
      step(0, ACT, 0, 0, "R8");
      step(0, WR,  1, 1, "R8");
      step(1, RD,  1, 0, "R7");
      step(1, NOP, 1, 0, "R7");
      step(1, RD,  0, 1, "R7");
      step(1, RD,  0, 0, "R12");
      step(1, NOP, 0, 0, "R12");
      // clock suspend with a command on the entry edge
      step(0, RD,  0, 1, "R4");
      step(0, WR,  0, 0, "R5");
      step(0, NOP, 1, 1, "R5");
      step(0, RD,  0, 0, "R5");
      step(1, WR,  0, 1, "R5");
      step(1, NOP, 0, 0, "R5");
      // refresh code with a bank open gives suspend, not self refresh
      step(0, REF, 0, 1, "R4");
      step(1, ACT, 0, 0, "R5");
      // immediate re-entry after suspend exit
      step(0, NOP, 0, 1, "R4");
      step(1, NOP, 1, 0, "R5");
      step(0, NOP, 1, 1, "R2");
      step(1, NOP, 1, 0, "R6");
      repeat (4) step(1, NOP, 1, 0, "R11");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule